// File: doc/BRIEF.md
# Destination-Routed Timeslot Switch

This block moves bytes from one 32-slot local serial line onto four expansion TDM streams. Each local timeslot has its own routing entry. The entry holds an enable, a target stream and a target slot. Bytes from the local line are gathered into a holding store over one frame. At the frame boundary the whole store is copied into an output store. During the next frame each expansion stream is shifted out from that output store. Every switched byte therefore arrives exactly one frame late, and a bundle of slots keeps its alignment.

A host port writes the routing entries, and a second small table of direct entries lets the host place a byte of its own on any expansion slot. Host writes are held until the next frame boundary. The block is its own timing master. One bit-enable strobe paces the expansion bit rate, and a one-cycle frame pulse marks slot 0, so the host can update a group of slots inside a single frame.

Top module: `tss_switch`

## Requirements
- R1: While reset is held and just after it, exp_drv is 0 and frame_sync is 0. With no routing written, every expansion bit reads 1.
- R2: frame_sync is high for exactly one clock at the start of slot 0. Consecutive pulses are 256, 512 or 1024 bit_en strobes apart at rate setting 0, 1 or 2.
- R3: A byte received in local slot L (MSB first, one local bit per 2^rate strobes) appears in the following frame, MSB first, on the stream and slot given by enabled entry L, and exp_drv is high for that slot.
- R4: An expansion slot that no enabled entry or direct entry targets outputs 0xFF with exp_drv low.
- R5: When several enabled entries target the same stream and slot, the byte of the highest-numbered local slot is output.
- R6: A routing write takes effect only at the next frame boundary. A write made in the middle of a frame leaves the rest of that frame unchanged.
- R7: An enabled direct entry (4 entries, index dw_idx) places dw_byte on its stream and slot and overrides any routed byte. Among direct entries the highest index wins. A direct entry written with dw_en=0 stops driving after the next boundary.
- R8: rate_sel is taken only at a frame boundary. 0 gives 32 slots per stream, 1 gives 64 and 2 gives 128; 3 acts as 2.
- R9: Counters, sampling and outputs advance only on clocks with bit_en high. Irregular strobes leave the routed data unchanged.
- R10: An entry written with rt_en=0 no longer drives its target after the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bit_en | input | 1 | expansion bit strobe |
| rate_sel | input | 2 | expansion rate: 0 = x1, 1 = x2, 2/3 = x4 |
| loc_si | input | 1 | local serial data in |
| rt_we | input | 1 | routing entry write |
| rt_idx | input | 5 | local slot whose entry is written |
| rt_en | input | 1 | entry enable |
| rt_stream | input | 2 | target stream |
| rt_slot | input | 7 | target expansion slot |
| dw_we | input | 1 | direct entry write |
| dw_idx | input | 2 | direct entry index |
| dw_en | input | 1 | direct entry enable |
| dw_stream | input | 2 | direct target stream |
| dw_slot | input | 7 | direct target slot |
| dw_byte | input | 8 | byte placed by the direct entry |
| exp_sd | output | 4 | serial data, one bit per expansion stream |
| exp_drv | output | 4 | per-stream drive enable for the current slot |
| frame_sync | output | 1 | one-clock pulse at the start of slot 0 |

## Verification
A corrupt active routing entry shows up in the very next frame as a byte at the wrong slot, or as a slot left idle. A swap at the wrong time breaks the one-frame alignment, so every routed byte is off by a frame within two frames. A fault in the bit counter or in the strobe gating moves the frame pulse or rotates the bits of each byte, and this can be seen in the first full frame after the fault. Checking every slot of every stream over whole frames exposes each of these within at most three frames.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int SLOT_BITS = 8;
  localparam int LOC_SLOTS = 32;
  localparam int LSLOT_W   = $clog2(LOC_SLOTS);
  localparam int N_STREAMS = 4;
  localparam int STR_W     = $clog2(N_STREAMS);
  localparam int MAX_RATE  = 2;
  localparam int XSLOT_W   = LSLOT_W + MAX_RATE;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int CNT_W     = XSLOT_W + BIT_W;
  localparam int N_DIRECT  = 4;
  localparam int DIDX_W    = $clog2(N_DIRECT);

  typedef logic [SLOT_BITS-1:0] byte_t;

  typedef struct packed {
    logic               en;
    logic [STR_W-1:0]   stream;
    logic [XSLOT_W-1:0] slot;
  } route_t;

  typedef struct packed {
    logic               en;
    logic [STR_W-1:0]   stream;
    logic [XSLOT_W-1:0] slot;
    byte_t              data;
  } direct_t;
endpackage

// File: rtl/tss_frame_timer.sv
module tss_frame_timer
  import tss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       rate_q,
  output logic             boundary,
  output logic             cap_strobe,
  output logic             frame_sync
);
  localparam int FRAME_BASE = LOC_SLOTS * SLOT_BITS;

  logic [CNT_W-1:0] cnt_q, cnt_d, last, mask;
  logic [1:0]       rate_d;
  logic             fs_d, fs_q;

  always_comb begin
    last       = CNT_W'((FRAME_BASE << rate_q) - 1);
    mask       = CNT_W'((1 << rate_q) - 1);
    boundary   = bit_en && (cnt_q == last);
    cap_strobe = bit_en && ((cnt_q & mask) == mask);
    cnt_d      = cnt_q;
    rate_d     = rate_q;
    if (bit_en) begin
      if (cnt_q == last) begin
        cnt_d  = '0;
        rate_d = (rate_sel > 2'(MAX_RATE)) ? 2'(MAX_RATE) : rate_sel;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    fs_d = boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
      fs_q   <= fs_d;
    end
  end

  assign cnt        = cnt_q;
  assign frame_sync = fs_q;

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);
  assert_sync_at_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (cnt_q == '0));
  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(rate_q));
  assert_rate_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q <= 2'(MAX_RATE));
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q));
endmodule

// File: rtl/tss_local_capture.sv
module tss_local_capture
  import tss_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cap_strobe,
  input  logic                            boundary,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [1:0]                      rate_q,
  input  logic                            loc_si,
  output logic [LOC_SLOTS-1:0][SLOT_BITS-1:0] out_bytes
);
  logic [7:0]                          lbit;
  logic [LSLOT_W-1:0]                  lslot;
  logic [SLOT_BITS-2:0]                sh_q, sh_d;
  logic [LOC_SLOTS-1:0][SLOT_BITS-1:0] hold_q, hold_d, out_q, out_d;

  always_comb begin
    lbit   = 8'(cnt >> rate_q);
    lslot  = lbit[7:BIT_W];
    sh_d   = sh_q;
    hold_d = hold_q;
    if (cap_strobe) begin
      sh_d = {sh_q[SLOT_BITS-3:0], loc_si};
      if (lbit[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1))
        hold_d[lslot] = {sh_q, loc_si};
    end
    out_d = boundary ? hold_d : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign out_bytes = out_q;

  assert_out_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(out_q));
endmodule

// File: rtl/tss_route_table.sv
module tss_route_table
  import tss_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         boundary,
  input  logic                         rt_we,
  input  logic [LSLOT_W-1:0]           rt_idx,
  input  route_t                       rt_entry,
  input  logic                         dw_we,
  input  logic [DIDX_W-1:0]            dw_idx,
  input  direct_t                      dw_entry,
  output route_t  [LOC_SLOTS-1:0]      act_route,
  output direct_t [N_DIRECT-1:0]       act_dir
);
  route_t  [LOC_SLOTS-1:0] pr_q, pr_d, ar_q, ar_d;
  direct_t [N_DIRECT-1:0]  pd_q, pd_d, ad_q, ad_d;

  always_comb begin
    pr_d = pr_q;
    pd_d = pd_q;
    if (rt_we) pr_d[rt_idx] = rt_entry;
    if (dw_we) pd_d[dw_idx] = dw_entry;
    ar_d = boundary ? pr_q : ar_q;
    ad_d = boundary ? pd_q : ad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= '0;
      pd_q <= '0;
      ar_q <= '0;
      ad_q <= '0;
    end else begin
      pr_q <= pr_d;
      pd_q <= pd_d;
      ar_q <= ar_d;
      ad_q <= ad_d;
    end
  end

  assign act_route = ar_q;
  assign act_dir   = ad_q;

  assert_route_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(ar_q));
  assert_direct_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(ad_q));
endmodule

// File: rtl/tss_stream_gather.sv
module tss_stream_gather
  import tss_pkg::*;
#(
  parameter int STREAM_ID = 0
) (
  input  logic [CNT_W-1:0]                    cnt,
  input  logic [LOC_SLOTS-1:0][SLOT_BITS-1:0] out_bytes,
  input  route_t  [LOC_SLOTS-1:0]             act_route,
  input  direct_t [N_DIRECT-1:0]              act_dir,
  output logic                                sd,
  output logic                                drv
);
  logic [XSLOT_W-1:0] xslot;
  logic [BIT_W-1:0]   bsel;
  byte_t              pick;
  logic               hit;

  always_comb begin
    xslot = cnt[CNT_W-1:BIT_W];
    bsel  = cnt[BIT_W-1:0];
    hit   = 1'b0;
    pick  = '1;
    for (int i = 0; i < LOC_SLOTS; i++) begin
      if (act_route[i].en && act_route[i].stream == STR_W'(STREAM_ID) &&
          act_route[i].slot == xslot) begin
        hit  = 1'b1;
        pick = out_bytes[i];
      end
    end
    for (int j = 0; j < N_DIRECT; j++) begin
      if (act_dir[j].en && act_dir[j].stream == STR_W'(STREAM_ID) &&
          act_dir[j].slot == xslot) begin
        hit  = 1'b1;
        pick = act_dir[j].data;
      end
    end
    sd  = pick[BIT_W'(SLOT_BITS - 1) - bsel];
    drv = hit;
  end
endmodule

// File: rtl/tss_switch.sv
module tss_switch
  import tss_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic [1:0]           rate_sel,
  input  logic                 loc_si,
  input  logic                 rt_we,
  input  logic [LSLOT_W-1:0]   rt_idx,
  input  logic                 rt_en,
  input  logic [STR_W-1:0]     rt_stream,
  input  logic [XSLOT_W-1:0]   rt_slot,
  input  logic                 dw_we,
  input  logic [DIDX_W-1:0]    dw_idx,
  input  logic                 dw_en,
  input  logic [STR_W-1:0]     dw_stream,
  input  logic [XSLOT_W-1:0]   dw_slot,
  input  logic [SLOT_BITS-1:0] dw_byte,
  output logic [N_STREAMS-1:0] exp_sd,
  output logic [N_STREAMS-1:0] exp_drv,
  output logic                 frame_sync
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0]                    cnt;
  logic [1:0]                          rate_q;
  logic                                boundary, cap_strobe;
  logic [LOC_SLOTS-1:0][SLOT_BITS-1:0] out_bytes;
  route_t  [LOC_SLOTS-1:0]             act_route;
  direct_t [N_DIRECT-1:0]              act_dir;
  route_t                              rt_entry;
  direct_t                             dw_entry;

  assign rt_entry = '{en: rt_en, stream: rt_stream, slot: rt_slot};
  assign dw_entry = '{en: dw_en, stream: dw_stream, slot: dw_slot, data: dw_byte};

  tss_frame_timer u_timer (
    .clk(clk), .rst_n(rst_int_n), .bit_en(bit_en), .rate_sel(rate_sel),
    .cnt(cnt), .rate_q(rate_q), .boundary(boundary),
    .cap_strobe(cap_strobe), .frame_sync(frame_sync)
  );

  tss_local_capture u_cap (
    .clk(clk), .rst_n(rst_int_n), .cap_strobe(cap_strobe), .boundary(boundary),
    .cnt(cnt), .rate_q(rate_q), .loc_si(loc_si), .out_bytes(out_bytes)
  );

  tss_route_table u_tab (
    .clk(clk), .rst_n(rst_int_n), .boundary(boundary),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_entry(rt_entry),
    .dw_we(dw_we), .dw_idx(dw_idx), .dw_entry(dw_entry),
    .act_route(act_route), .act_dir(act_dir)
  );

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    tss_stream_gather #(.STREAM_ID(s)) u_gather (
      .cnt(cnt), .out_bytes(out_bytes), .act_route(act_route), .act_dir(act_dir),
      .sd(exp_sd[s]), .drv(exp_drv[s])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |-> (exp_drv == '0 && !frame_sync));
endmodule

// File: tb/tss_switch_tb_top.sv
module tss_switch_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, bit_en, loc_si;
  logic [1:0] rate_sel;
  logic       rt_we, rt_en, dw_we, dw_en;
  logic [4:0] rt_idx;
  logic [1:0] rt_stream, dw_idx, dw_stream;
  logic [6:0] rt_slot, dw_slot;
  logic [7:0] dw_byte;
  logic [3:0] exp_sd, exp_drv;
  logic       frame_sync;

  tss_switch dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_sel(rate_sel), .loc_si(loc_si),
    .rt_we(rt_we), .rt_idx(rt_idx), .rt_en(rt_en), .rt_stream(rt_stream), .rt_slot(rt_slot),
    .dw_we(dw_we), .dw_idx(dw_idx), .dw_en(dw_en), .dw_stream(dw_stream), .dw_slot(dw_slot),
    .dw_byte(dw_byte), .exp_sd(exp_sd), .exp_drv(exp_drv), .frame_sync(frame_sync)
  );

  // vector: {local slot, stream, expansion slot, byte}
  localparam logic [21:0] VEC [8] = '{
    {5'd0,  2'd0, 7'd5,  8'hA5}, {5'd1,  2'd1, 7'd0,  8'h3C},
    {5'd7,  2'd2, 7'd31, 8'h81}, {5'd12, 2'd3, 7'd16, 8'h00},
    {5'd19, 2'd0, 7'd6,  8'hFE}, {5'd25, 2'd1, 7'd30, 8'h5A},
    {5'd30, 2'd2, 7'd2,  8'h7F}, {5'd31, 2'd3, 7'd31, 8'hC3}
  };

  int n_cmp = 0, n_bad = 0;
  int pos = 0, r = 0, got_r = 0, nfr = 0, strobes = 0, last_len = 0, cyc = 0;
  int xs, bi, lb;
  bit stall = 0;
  logic [7:0] cur_in [32], nxt_in [32], prv_in [32], got_src [32];
  logic [7:0] cap_b [4][128], got_b [4][128];
  logic       cap_d [4][128], got_d [4][128];
  bit         m_en [32];
  int         m_str [32], m_slot [32];
  bit         d_en [4];
  int         d_str [4], d_slot [4];
  logic [7:0] d_byte [4];

  always @(negedge clk) begin
    cyc++;
    if (bit_en === 1'b1) strobes++;
    if (frame_sync === 1'b1) begin
      got_b = cap_b; got_d = cap_d; got_r = r;
      got_src = prv_in; prv_in = cur_in; cur_in = nxt_in;
      last_len = strobes; strobes = 0;
      r = (rate_sel > 2) ? 2 : int'(rate_sel);
      pos = 0;
      nfr++;
    end else if (bit_en === 1'b1) pos++;
    xs = (pos >> 3) & 127;
    bi = pos & 7;
    for (int s = 0; s < 4; s++) begin
      cap_b[s][xs][7-bi] = exp_sd[s];
      if (bi == 0) cap_d[s][xs] = exp_drv[s];
    end
    lb = (pos >> r) & 255;
    loc_si = cur_in[lb >> 3][7 - (lb & 7)];
    bit_en = stall ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wait_frames(input int n);
    int t = nfr + n;
    wait (nfr >= t);
  endtask

  task automatic wr_route(input int idx, input bit en, input int str, input int slot, input bit upd);
    @(negedge clk);
    rt_we = 1; rt_idx = 5'(idx); rt_en = en; rt_stream = 2'(str); rt_slot = 7'(slot);
    @(negedge clk);
    rt_we = 0;
    if (upd) begin m_en[idx] = en; m_str[idx] = str; m_slot[idx] = slot; end
  endtask

  task automatic wr_direct(input int idx, input bit en, input int str, input int slot, input logic [7:0] b);
    @(negedge clk);
    dw_we = 1; dw_idx = 2'(idx); dw_en = en; dw_stream = 2'(str); dw_slot = 7'(slot); dw_byte = b;
    @(negedge clk);
    dw_we = 0;
    d_en[idx] = en; d_str[idx] = str; d_slot[idx] = slot; d_byte[idx] = b;
  endtask

  function automatic logic [8:0] model(input int s, input int t);
    logic [8:0] v = 9'h0FF;
    for (int i = 0; i < 32; i++)
      if (m_en[i] && m_str[i] == s && m_slot[i] == t) v = {1'b1, got_src[i]};
    for (int j = 0; j < 4; j++)
      if (d_en[j] && d_str[j] == s && d_slot[j] == t) v = {1'b1, d_byte[j]};
    return v;
  endfunction

  function automatic logic [8:0] got(input int s, input int t);
    return {got_d[s][t], got_b[s][t]};
  endfunction

  task automatic check_frame(input string req);
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < (32 << got_r); t++)
        chk(got(s, t) === model(s, t), req, got(s, t), model(s, t));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 0; rate_sel = 0;
    rt_we = 0; rt_idx = 0; rt_en = 0; rt_stream = 0; rt_slot = 0;
    dw_we = 0; dw_idx = 0; dw_en = 0; dw_stream = 0; dw_slot = 0; dw_byte = 0;
    for (int i = 0; i < 32; i++) begin
      nxt_in[i] = 8'(8'h10 + i); cur_in[i] = 0; prv_in[i] = 0; got_src[i] = 0;
      m_en[i] = 0; m_str[i] = 0; m_slot[i] = 0;
    end
    for (int j = 0; j < 4; j++) begin d_en[j] = 0; d_str[j] = 0; d_slot[j] = 0; d_byte[j] = 0; end

    // R1: reset state
    repeat (5) @(negedge clk);
    chk(exp_drv == 4'h0 && frame_sync == 1'b0, "R1", {exp_drv, 3'b0, frame_sync}, 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    chk(exp_drv == 4'h0 && exp_sd == 4'hF, "R1", {exp_drv, exp_sd}, 8'h0F);
    wait_frames(2);
    check_frame("R1/R4 idle");
    chk(last_len == 256, "R2", last_len, 256);

    // R3: vector table walk
    for (int v = 0; v < 8; v++) begin
      wr_route(int'(VEC[v][21:17]), 1, int'(VEC[v][16:15]), int'(VEC[v][14:8]), 1);
      nxt_in[VEC[v][21:17]] = VEC[v][7:0];
    end
    wait_frames(3);
    for (int v = 0; v < 8; v++)
      chk(got(int'(VEC[v][16:15]), int'(VEC[v][14:8])) === {1'b1, VEC[v][7:0]}, "R3",
          got(int'(VEC[v][16:15]), int'(VEC[v][14:8])), {1'b1, VEC[v][7:0]});
    chk(got(0, 0) === 9'h0FF, "R4", got(0, 0), 9'h0FF);
    check_frame("R3");

    // R5: collision, higher local slot wins; R10: disable
    nxt_in[3] = 8'h11; nxt_in[20] = 8'h22;
    wr_route(3, 1, 1, 10, 1);
    wr_route(20, 1, 1, 10, 1);
    wait_frames(3);
    chk(got(1, 10) === 9'h122, "R5", got(1, 10), 9'h122);
    check_frame("R5");
    wr_route(20, 0, 1, 10, 1);
    wait_frames(2);
    chk(got(1, 10) === 9'h111, "R10", got(1, 10), 9'h111);

    // R6: mid-frame write does not alter current frame
    wait_frames(1);
    repeat (100) @(negedge clk);
    wr_route(3, 1, 2, 20, 0);
    wait_frames(1);
    chk(got(1, 10) === 9'h111, "R6", got(1, 10), 9'h111);
    chk(got(2, 20) === 9'h0FF, "R6", got(2, 20), 9'h0FF);
    m_en[3] = 1; m_str[3] = 2; m_slot[3] = 20;
    wait_frames(1);
    chk(got(2, 20) === 9'h111, "R6", got(2, 20), 9'h111);
    check_frame("R6");

    // R7: direct entries
    wr_direct(0, 1, 2, 20, 8'h99);
    wr_direct(1, 1, 0, 1, 8'h42);
    wr_direct(2, 1, 2, 20, 8'h77);
    wait_frames(2);
    chk(got(2, 20) === 9'h177, "R7", got(2, 20), 9'h177);
    chk(got(0, 1) === 9'h142, "R7", got(0, 1), 9'h142);
    wr_direct(2, 0, 2, 20, 8'h77);
    wait_frames(2);
    chk(got(2, 20) === 9'h199, "R7", got(2, 20), 9'h199);
    check_frame("R7");

    // R9: irregular strobes
    stall = 1;
    wait_frames(3);
    chk(last_len == 256, "R9", last_len, 256);
    check_frame("R9");
    stall = 0;
    wait_frames(1);

    // R8: rate settings
    rate_sel = 1;
    wr_route(4, 1, 0, 50, 1);
    nxt_in[4] = 8'hB4;
    wait_frames(3);
    chk(last_len == 512, "R8", last_len, 512);
    chk(got(0, 50) === 9'h1B4, "R8", got(0, 50), 9'h1B4);
    check_frame("R8 x2");
    rate_sel = 3;
    wr_route(5, 1, 3, 127, 1);
    nxt_in[5] = 8'h6D;
    wait_frames(3);
    chk(last_len == 1024, "R8", last_len, 1024);
    chk(got(3, 127) === 9'h16D, "R8", got(3, 127), 9'h16D);
    check_frame("R8 x4");

    summary();
  end
endmodule